// File: doc/BRIEF.md
# Keyed Watchdog Countdown Timer

This block is a register-mapped watchdog. A 32-bit counter counts down toward zero, either once per system clock cycle or once per microsecond tick taken from an internal prescaler. Software arms it by writing a reload value and then a fixed key word. It keeps the system alive by writing that key again before the count runs out. Any other value written to the key port does nothing.

When the count reaches zero while counting is enabled, the block records the timeout in a sticky status register. It can raise a one-cycle reset request, tagged with a reset-scope code, and a one-cycle trigger for an external pulse shaper. It can also latch a request to boot from the alternate flash. After expiry the counter stops until it is re-keyed or re-enabled. An optional early-warning interrupt fires when the count passes a programmable threshold held in the upper control bits. That interrupt stays raised until software clears the status.

The register port is a plain valid/write/address/data interface. Read data is combinational on the word address. Writes take effect on the clock edge where valid and write are both high.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control word reads 0, the reload value reads 0xFFFFFFFF, the count reads 0xFFFFFFFF, the status reads 0, and rst_req, ext_trig, irq and boot_alt are low with rst_scope 00.
- R2: Register words sit at byte offsets 0x00 count (read), 0x04 reload, 0x08 key port, 0x0C control, 0x10 status, 0x14 status clear. The key and clear ports read as 0. A write hits only when address bits 1:0 are 0.
- R3: Writing exactly 0x00004755 to the key port copies the reload value into the count on the next edge. Any other value written there leaves the count unchanged.
- R4: Control bit 0 enables counting. While it is clear the count holds its value.
- R5: Control bit 4 set makes the count step once per CLK_HZ/TICK_HZ clock cycles. With bit 4 clear it steps on every clock cycle.
- R6: From a reload of N ≥ 1, the count reaches 0 after N steps. On the same edge status bit 0 sets. rst_req pulses for one cycle if control bit 1 is set, and ext_trig pulses for one cycle if control bit 3 is set. rst_scope takes control bits 6:5 (00 SoC, 01 full chip, 10 CPU) at that edge and holds them.
- R7: After expiry the count stays at 0 until the key is written or control bit 0 goes from 0 to 1. Re-enabling with a count of 0 expires again on the next step.
- R8: An expiry with control bit 7 set sets status bit 1, which drives boot_alt.
- R9: With control bits 0 and 2 set, when the count equals {control[31:10], 10'b0} (nonzero), status bit 2 sets and drives irq. It stays set until cleared. With bit 2 clear it never sets.
- R10: Writing a word with bit 0 set to the clear port clears status bits 2:0, and clearing takes priority over a same-cycle event. A write to the clear port with bit 0 clear changes nothing.
- R11: The sequence control=0, reload=V, key, control with enable set loads V and then counts down from V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | High for a write when bus_valid is high |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_scope | output | 2 | Reset scope captured at the last expiry |
| ext_trig | output | 1 | One-cycle trigger for the external pulse shaper |
| boot_alt | output | 1 | Alternate-boot selection (status bit 1) |
| irq | output | 1 | Early-warning interrupt (status bit 2) |

## Verification
The countdown runs both in every-cycle mode and in prescaled mode over windows of known length. The two modes give different remaining counts, so a wrong tick source or a wrong divide ratio shows up. Expiry is sampled in the cycles just before, during and after the zero crossing. This catches off-by-one step counts and pulses that last longer than one cycle. It is repeated with the reset and external bits off, and again after re-enabling with a count of zero, which tells the halt logic apart from a free-running counter. The key port is written with near-miss values, and the early-warning threshold is run with its enable on and off.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int CNT_W   = 32;
  localparam int THR_LSB = 10;
  localparam int THR_W   = CNT_W - THR_LSB;
  localparam int ST_W    = 3;

  localparam logic [CNT_W-1:0] KICK_KEY = 32'h0000_4755;

  // word indices (byte offset / 4)
  localparam int W_COUNT  = 0;
  localparam int W_RELOAD = 1;
  localparam int W_KICK   = 2;
  localparam int W_CTRL   = 3;
  localparam int W_STAT   = 4;
  localparam int W_CLEAR  = 5;

  // control bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_RST   = 1;
  localparam int CB_PRE   = 2;
  localparam int CB_EXT   = 3;
  localparam int CB_TICK  = 4;
  localparam int CB_SCOPE = 5;
  localparam int CB_ALT   = 7;

  // status bit positions
  localparam int SB_EXPIRED = 0;
  localparam int SB_ALT     = 1;
  localparam int SB_PRE     = 2;
endpackage

// File: rtl/kwdt_rst_sync.sv
module kwdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    tick = (pc_q >= LAST);
    pc_d = tick ? '0 : pc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/kwdt_regfile.sv
module kwdt_regfile
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              fire,
  input  logic              pre_hit,
  output logic [CNT_W-1:0]  ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              kick,
  output logic              run_rise,
  output logic [ST_W-1:0]   stat_q
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              wr;
  logic              clr;
  logic [CNT_W-1:0]  ctrl_d, reload_d;
  logic [ST_W-1:0]   stat_d, stat_set;

  assign word = bus_addr[ADDR_W-1:2];

  always_comb begin
    wr       = bus_valid && bus_write && (bus_addr[1:0] == 2'b00);
    kick     = wr && (word == WORD_W'(W_KICK)) && (bus_wdata == KICK_KEY);
    run_rise = wr && (word == WORD_W'(W_CTRL)) && bus_wdata[CB_RUN] && !ctrl_q[CB_RUN];
    clr      = wr && (word == WORD_W'(W_CLEAR)) && bus_wdata[0];

    ctrl_d   = (wr && word == WORD_W'(W_CTRL))   ? bus_wdata : ctrl_q;
    reload_d = (wr && word == WORD_W'(W_RELOAD)) ? bus_wdata : reload_q;

    stat_set             = '0;
    stat_set[SB_EXPIRED] = fire;
    stat_set[SB_ALT]     = fire && ctrl_q[CB_ALT];
    stat_set[SB_PRE]     = pre_hit;
    stat_d = clr ? '0 : (stat_q | stat_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '1;
      stat_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      stat_q   <= stat_d;
    end
  end

  always_comb begin
    case (word)
      WORD_W'(W_COUNT):  bus_rdata = cnt_val;
      WORD_W'(W_RELOAD): bus_rdata = reload_q;
      WORD_W'(W_CTRL):   bus_rdata = ctrl_q;
      WORD_W'(W_STAT):   bus_rdata = {{(CNT_W-ST_W){1'b0}}, stat_q};
      default:           bus_rdata = '0;
    endcase
  end

  // R9: the early-warning flag is sticky until cleared
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[SB_PRE] && !clr |=> stat_q[SB_PRE]);

  // R10: a clear write empties the status on the next edge
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat_q == '0));

  // R2: a key-port or count-port write never alters the control word
  a_r2_ctrl_only_own_word: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && word == WORD_W'(W_CTRL)) |=> $stable(ctrl_q));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic             kick,
  input  logic             run_rise,
  input  logic [CNT_W-1:0] reload,
  input  logic             rst_en,
  input  logic             ext_en,
  input  logic             pre_en,
  input  logic [THR_W-1:0] thr,
  input  logic [1:0]       scope_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire,
  output logic             pre_hit,
  output logic             rst_req,
  output logic             ext_trig,
  output logic [1:0]       rst_scope
);
  logic             halt_q, halt_d;
  logic             run;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] thr_full;

  always_comb begin
    run      = en && !halt_q && step;
    fire     = !kick && run && (cnt_q <= CNT_W'(1));
    thr_full = {thr, {THR_LSB{1'b0}}};
    pre_hit  = en && pre_en && !halt_q && (thr != '0) && (cnt_q == thr_full);

    cnt_d = cnt_q;
    if (kick)     cnt_d = reload;
    else if (run) cnt_d = fire ? '0 : cnt_q - CNT_W'(1);

    halt_d = halt_q;
    if (kick || run_rise) halt_d = 1'b0;
    else if (fire)        halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      halt_q    <= 1'b0;
      rst_req   <= 1'b0;
      ext_trig  <= 1'b0;
      rst_scope <= 2'b00;
    end else begin
      cnt_q    <= cnt_d;
      halt_q   <= halt_d;
      rst_req  <= fire && rst_en;
      ext_trig <= fire && ext_en;
      if (fire) rst_scope <= scope_in;
    end
  end

  // R3: a key write loads the reload value
  a_r3_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == $past(reload)));

  // R4: disabled counter holds
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !kick |=> $stable(cnt_q));

  // R6: reset request is a single-cycle pulse and coincides with a zero count
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r6_zero_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_q == '0));

  // R7: once halted the count does not move without a key write
  a_r7_halted_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && !kick |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int CLK_HZ  = 250_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req,
  output logic [1:0]        rst_scope,
  output logic              ext_trig,
  output logic              boot_alt,
  output logic              irq
);
  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic             rs_n;
  logic             tick, step;
  logic [CNT_W-1:0] ctrl_q, reload_q, cnt_q;
  logic             kick, run_rise, fire, pre_hit;
  logic [ST_W-1:0]  stat_q;

  kwdt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rs_n)
  );

  kwdt_prescaler #(.DIV(DIV)) u_prescaler (
    .clk   (clk),
    .rst_n (rs_n),
    .tick  (tick)
  );

  assign step = ctrl_q[CB_TICK] ? tick : 1'b1;

  kwdt_regfile #(.ADDR_W(ADDR_W)) u_regfile (
    .clk       (clk),
    .rst_n     (rs_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_val   (cnt_q),
    .fire      (fire),
    .pre_hit   (pre_hit),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .kick      (kick),
    .run_rise  (run_rise),
    .stat_q    (stat_q)
  );

  kwdt_counter u_counter (
    .clk       (clk),
    .rst_n     (rs_n),
    .en        (ctrl_q[CB_RUN]),
    .step      (step),
    .kick      (kick),
    .run_rise  (run_rise),
    .reload    (reload_q),
    .rst_en    (ctrl_q[CB_RST]),
    .ext_en    (ctrl_q[CB_EXT]),
    .pre_en    (ctrl_q[CB_PRE]),
    .thr       (ctrl_q[CNT_W-1:THR_LSB]),
    .scope_in  (ctrl_q[CB_SCOPE+1:CB_SCOPE]),
    .cnt_q     (cnt_q),
    .fire      (fire),
    .pre_hit   (pre_hit),
    .rst_req   (rst_req),
    .ext_trig  (ext_trig),
    .rst_scope (rst_scope)
  );

  assign boot_alt = stat_q[SB_ALT];
  assign irq      = stat_q[SB_PRE];

  // R8: alternate-boot flag only rises on an expiry
  a_r8_alt_from_expiry: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(boot_alt) |-> $past(fire));

  // R5: in prescaled mode the count never moves on two adjacent edges
  a_r5_prescaled_gap: assert property (@(posedge clk) disable iff (!rs_n)
    (DIV > 1) && ctrl_q[CB_TICK] && $past(ctrl_q[CB_TICK]) && !kick && !$past(kick)
      && ($past(cnt_q) != cnt_q) |=> (kick || $stable(cnt_q)));
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  logic        clk;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rst_req, ext_trig, boot_alt, irq;
  logic [1:0]  rst_scope;

  int n_run  = 0;
  int n_fail = 0;
  int rst_cnt = 0;
  int ext_cnt = 0;

  localparam logic [4:0] A_CNT = 5'h00, A_REL = 5'h04, A_KICK = 5'h08,
                         A_CTRL = 5'h0C, A_STAT = 5'h10, A_CLR = 5'h14;
  localparam logic [31:0] KEY = 32'h0000_4755;

  typedef struct {
    logic        pins;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  sample_ev;

  keyed_wdt #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000), .ADDR_W(5)) i_keyed_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .rst_scope (rst_scope),
    .ext_trig  (ext_trig),
    .boot_alt  (boot_alt),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_req)  rst_cnt++;
    if (ext_trig) ext_cnt++;
  end

  // monitor: pops expected items and compares them against the design
  initial forever begin
    @(sample_ev);
    #1;
    if (q.size() == 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: sample with empty queue");
    end else begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.pins ? {26'd0, rst_scope, boot_alt, irq, ext_trig, rst_req} : bus_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.pins = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
    @(negedge clk);
  endtask

  // pins = {rst_scope[1:0], boot_alt, irq, ext_trig, rst_req}
  task automatic pins(input logic [31:0] e, input string tag);
    item_t it;
    it.pins = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: reset values and read map
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_REL,  32'hFFFF_FFFF, "R1 reload");
    rd(A_CNT,  32'hFFFF_FFFF, "R1 count");
    rd(A_STAT, 32'h0, "R1 status");
    pins(32'h00, "R1 outputs");
    rd(A_KICK, 32'h0, "R2 key port reads 0");
    rd(A_CLR,  32'h0, "R2 clear port reads 0");

    // R3: exact key loads, near misses are ignored
    wr(A_REL, 32'd77);
    wr(A_KICK, KEY);
    rd(A_CNT, 32'd77, "R3 key loads");
    wr(A_REL, 32'd99);
    wr(A_KICK, 32'h0000_4756);
    rd(A_CNT, 32'd77, "R3 wrong key ignored");
    wr(A_KICK, 32'h0001_4755);
    rd(A_CNT, 32'd77, "R3 upper bits ignored");
    wr(A_KICK + 5'd1, KEY);
    rd(A_CNT, 32'd77, "R2 unaligned write ignored");
    wr(A_KICK, KEY);
    rd(A_CNT, 32'd99, "R3 key loads new reload");

    // R4: every-cycle stepping over a known window, then hold
    wr(A_REL, 32'd1000);
    wr(A_KICK, KEY);
    wr(A_CTRL, 32'h1);
    repeat (9) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd990, "R4 ten steps");
    repeat (10) @(negedge clk);
    rd(A_CNT, 32'd990, "R4 hold when disabled");

    // R5: prescaled stepping, 80 edges at divide-by-4
    wr(A_KICK, KEY);
    wr(A_CTRL, 32'h11);
    repeat (79) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd980, "R5 prescaled steps");

    // R6 / R8: expiry with reset, external, scope 01, alternate boot
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd5);
    wr(A_KICK, KEY);
    wr(A_CTRL, 32'hAB);
    repeat (4) @(negedge clk);
    pins(32'h00, "R6 no pulse before zero");
    pins(32'h1B, "R6 pulse at zero");
    pins(32'h18, "R6 pulse lasts one cycle");
    rd(A_STAT, 32'h3, "R8 status expired and alternate");
    rd(A_CTRL, 32'hAB, "R2 control readback");

    // R7: halted at zero
    repeat (10) @(negedge clk);
    rd(A_CNT, 32'h0, "R7 halted count");
    chk(rst_cnt, 1, "R7 single reset pulse");
    chk(ext_cnt, 1, "R6 single external pulse");
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'hAB);
    repeat (5) @(negedge clk);
    chk(rst_cnt, 2, "R7 re-enable expires again");

    // R10: clear port
    wr(A_CLR, 32'h0);
    rd(A_STAT, 32'h3, "R10 clear with bit0 low ignored");
    wr(A_CLR, 32'h1);
    rd(A_STAT, 32'h0, "R10 clear");
    pins(32'h10, "R10 boot_alt dropped");

    // R11: reprogramming sequence
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd300);
    wr(A_KICK, KEY);
    rd(A_CNT, 32'd300, "R11 loaded");
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd299, "R11 counts from new value");

    // R6: expiry without reset or external enables
    wr(A_REL, 32'd2);
    wr(A_KICK, KEY);
    wr(A_CTRL, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_STAT, 32'h1, "R6 expired flag only");
    rd(A_CNT, 32'h0, "R6 count at zero");
    pins(32'h00, "R6 scope 00 captured, no pulses");
    chk(rst_cnt, 2, "R6 no reset pulse when disabled");
    chk(ext_cnt, 2, "R6 no external pulse when disabled");
    wr(A_CLR, 32'h1);

    // R9: early warning at threshold 1024
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd1030);
    wr(A_KICK, KEY);
    wr(A_CTRL, 32'h405);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, 32'h4, "R9 early warning flag");
    pins(32'h04, "R9 irq high");
    repeat (10) @(negedge clk);
    pins(32'h04, "R9 irq sticky");
    wr(A_CLR, 32'h0);
    pins(32'h04, "R10 irq kept on bit0 low");
    wr(A_CLR, 32'h1);
    pins(32'h00, "R10 irq cleared");

    // R9: disabled early warning never fires
    wr(A_KICK, KEY);
    wr(A_CTRL, 32'h401);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, 32'h0, "R9 disabled early warning");

    repeat (3) @(negedge clk);
    chk(q.size(), 0, "scoreboard drained");
    summary();
    $finish;
  end
endmodule